// File: doc/BRIEF.md
# Deferred Posted-Write Bus Error Tracker

This block holds a bus error reported against a posted write: a final write that was still in flight after the next instruction had begun executing. The instruction that issued such a write has already retired, so it cannot be restarted. The block therefore keeps the fault pending and raises it later, at one of two points. The first is the next instruction boundary. The second is earlier: the moment the sequencer asks for an operand access while the fault is still held. In that case the new instruction is aborted, so it never uses stale memory contents.

When the fault is taken, the block raises a one-cycle exception request. It freezes the exception flags that are pending at that moment, along with the status register and the address of the next unexecuted instruction. It then streams a stack frame as 16-bit words over a valid/ready port. The first word is a special status word with a fixed pattern. It is followed by the status register, the next program counter, the faulting address and the data that was meant to be written. A second error that arrives while one is already held is dropped, and a sticky flag records that this happened.

Top module: `rwf_tracker`

## Requirements
- R1: A write error (`wr_err_valid` high) that arrives while no fault is held is captured with its address, data, size, long flag and function code. Capturing alone never raises `exc_req`.
- R2: While a fault is held and not yet being stacked, an `insn_boundary` pulse takes the fault. `exc_req` is high for exactly the one cycle after that edge, and `op_abort` stays low.
- R3: While a fault is held and not yet being stacked, an `operand_req` pulse takes the fault at once. `exc_req` and `op_abort` are both high for the one cycle after that edge.
- R4: A boundary or operand request has no effect when no fault is held, including in the same cycle as the capturing error.
- R5: The first stacked word is the special status word. Bits 15:13 are 0. Bit 12 is trace pending. Bit 11 is breakpoint 1 pending. Bit 10 is breakpoint 0 pending. Bit 9 is 1. Bits 8:6 are 0. Bit 5 is the long flag. Bits 4:3 are the size. Bits 2:0 are the function code.
- R6: The trace and breakpoint bits of the status word, `cur_sr` and `next_pc` are all sampled in the cycle the fault is taken. Values before or after that cycle do not affect them.
- R7: The frame has 2 + 2·AW/16 + DW/16 words, in this order: status word, status register, next PC (most significant half first), fault address (most significant half first), write data (most significant half first).
- R8: `stk_valid` rises in the cycle after the take. Each cycle with `stk_valid` and `stk_ready` both high consumes one word. While `stk_ready` is low, `stk_data` holds steady.
- R9: After the last word is consumed, `stk_valid` falls and the fault is released. An error arriving after that point is captured again.
- R10: A write error that arrives while a fault is held, whether pending or being stacked, leaves the held fault unchanged and sets `overflow`. `overflow` stays set until reset.
- R11: During reset, `exc_req`, `op_abort`, `stk_valid`, `stk_data` and `overflow` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_err_valid | input | 1 | Posted write returned a bus error |
| wr_err_addr | input | AW | Address of the failed write |
| wr_err_data | input | DW | Data of the failed write |
| wr_err_size | input | 2 | Transfer size code |
| wr_err_long | input | 1 | Long-operand flag |
| wr_err_fc | input | 3 | Function code of the failed write |
| insn_boundary | input | 1 | Instruction boundary strobe |
| operand_req | input | 1 | Operand access request strobe |
| pend_trace | input | 1 | Trace exception pending |
| pend_brk1 | input | 1 | Breakpoint 1 pending |
| pend_brk0 | input | 1 | Breakpoint 0 pending |
| cur_sr | input | 16 | Current status register |
| next_pc | input | AW | Address of next unexecuted instruction |
| stk_ready | input | 1 | Stack sink accepts a word |
| exc_req | output | 1 | One-cycle exception request |
| op_abort | output | 1 | Abort the requesting instruction |
| stk_valid | output | 1 | Stack word valid |
| stk_data | output | 16 | Stack word |
| overflow | output | 1 | Sticky: an error was dropped |

## Verification
The bench builds the block with AW = 32 and DW = 32. This gives an eight-word frame in which every multi-word field is split into two halves, so the half ordering of R7 and the stall behaviour of R8 can be observed across several handshakes. Directed sequences cover a take at a boundary, a take on an operand request, a trigger in the same cycle as the capture, and errors that collide with a pending fault and with a frame being stacked. A long random run then mixes all of these with a stalling sink, and a behavioural model built on a word queue is compared against the outputs on every cycle.

// File: rtl/rwf_pkg.sv
package rwf_pkg;

  localparam int WORD_W = 16;

  typedef struct packed {
    logic tr;
    logic b1;
    logic b0;
  } pend_flags_t;

  function automatic logic [WORD_W-1:0] make_ssw(
    input pend_flags_t fl,
    input logic        lg,
    input logic [1:0]  siz,
    input logic [2:0]  fc
  );
    logic [WORD_W-1:0] w;
    w        = '0;
    w[12]    = fl.tr;
    w[11]    = fl.b1;
    w[10]    = fl.b0;
    w[9]     = 1'b1;
    w[5]     = lg;
    w[4:3]   = siz;
    w[2:0]   = fc;
    return w;
  endfunction

endpackage

// File: rtl/rwf_capture.sv
module rwf_capture #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          err_valid,
  input  logic [AW-1:0] err_addr,
  input  logic [DW-1:0] err_data,
  input  logic [1:0]    err_size,
  input  logic          err_long,
  input  logic [2:0]    err_fc,
  input  logic          release_i,
  output logic          held,
  output logic          ovf,
  output logic [AW-1:0] f_addr,
  output logic [DW-1:0] f_data,
  output logic [1:0]    f_size,
  output logic          f_long,
  output logic [2:0]    f_fc
);

  always_ff @(posedge clk) begin
    if (rst) begin
      held <= 1'b0;
      ovf  <= 1'b0;
    end else begin
      if (err_valid) begin
        if (held) begin
          ovf <= 1'b1;
        end else begin
          held <= 1'b1;
        end
      end
      if (release_i) held <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (err_valid && !held) begin
      f_addr <= err_addr;
      f_data <= err_data;
      f_size <= err_size;
      f_long <= err_long;
      f_fc   <= err_fc;
    end
  end

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf); // R10
  AST_HELD_ADDR_KEPT: assert property (@(posedge clk) disable iff (rst)
    held && !release_i |=> held && $stable(f_addr) && $stable(f_data)); // R10

endmodule

// File: rtl/rwf_sequencer.sv
module rwf_sequencer (
  input  logic clk,
  input  logic rst,
  input  logic held,
  input  logic boundary,
  input  logic opreq,
  input  logic sink_ready,
  input  logic last_word,
  output logic take,
  output logic advance,
  output logic release_o,
  output logic stacking,
  output logic exc_req,
  output logic op_abort
);

  always_comb begin
    take      = held && !stacking && (boundary || opreq);
    advance   = stacking && sink_ready;
    release_o = advance && last_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stacking <= 1'b0;
      exc_req  <= 1'b0;
      op_abort <= 1'b0;
    end else begin
      exc_req  <= take;
      op_abort <= take && opreq;
      if (take)           stacking <= 1'b1;
      else if (release_o) stacking <= 1'b0;
    end
  end

  AST_EXC_PULSE: assert property (@(posedge clk) disable iff (rst)
    exc_req |=> !exc_req); // R2
  AST_ABORT_WITH_EXC: assert property (@(posedge clk) disable iff (rst)
    op_abort |-> exc_req); // R3
  AST_STACK_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(stacking) |-> exc_req); // R8
  AST_END_OF_FRAME: assert property (@(posedge clk) disable iff (rst)
    release_o |=> !stacking); // R9
  AST_TAKE_NEEDS_FAULT: assert property (@(posedge clk) disable iff (rst)
    exc_req |-> stacking); // R4

endmodule

// File: rtl/rwf_stacker.sv
module rwf_stacker import rwf_pkg::*; #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic          advance,
  input  logic          active,
  input  pend_flags_t   flags,
  input  logic [15:0]   sr,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] f_addr,
  input  logic [DW-1:0] f_data,
  input  logic [1:0]    f_size,
  input  logic          f_long,
  input  logic [2:0]    f_fc,
  output logic [15:0]   word,
  output logic          last_word
);

  localparam int NW = 2 + 2 * (AW / WORD_W) + DW / WORD_W;
  localparam int IW = $clog2(NW);
  localparam int FW = WORD_W * NW;
  localparam logic [IW-1:0] LAST_IDX = IW'(NW - 1);

  logic [IW-1:0]     idx;
  logic [15:0]       ssw_q;
  logic [15:0]       sr_q;
  logic [AW-1:0]     pc_q;
  logic [FW-1:0]     frame;
  logic [15:0]       next_word;
  int                nxt;

  always_comb begin
    frame     = {ssw_q, sr_q, pc_q, f_addr, f_data};
    nxt       = int'(idx) + 1;
    if (nxt > NW - 1) nxt = NW - 1;
    next_word = frame[FW - 1 - WORD_W * nxt -: WORD_W];
    last_word = (idx == LAST_IDX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx   <= '0;
      word  <= '0;
      ssw_q <= '0;
      sr_q  <= '0;
      pc_q  <= '0;
    end else if (take) begin
      idx   <= '0;
      ssw_q <= make_ssw(flags, f_long, f_size, f_fc);
      word  <= make_ssw(flags, f_long, f_size, f_fc);
      sr_q  <= sr;
      pc_q  <= pc;
    end else if (advance && !last_word) begin
      idx  <= idx + 1'b1;
      word <= next_word;
    end
  end

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
    active && !advance |=> $stable(word) && $stable(idx)); // R8
  AST_SSW_MARK: assert property (@(posedge clk) disable iff (rst)
    active && idx == '0 |-> word[9] && word[15:13] == 3'b000 && word[8:6] == 3'b000); // R5

endmodule

// File: rtl/rwf_tracker.sv
module rwf_tracker import rwf_pkg::*; #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_err_valid,
  input  logic [AW-1:0] wr_err_addr,
  input  logic [DW-1:0] wr_err_data,
  input  logic [1:0]    wr_err_size,
  input  logic          wr_err_long,
  input  logic [2:0]    wr_err_fc,
  input  logic          insn_boundary,
  input  logic          operand_req,
  input  logic          pend_trace,
  input  logic          pend_brk1,
  input  logic          pend_brk0,
  input  logic [15:0]   cur_sr,
  input  logic [AW-1:0] next_pc,
  input  logic          stk_ready,
  output logic          exc_req,
  output logic          op_abort,
  output logic          stk_valid,
  output logic [15:0]   stk_data,
  output logic          overflow
);

  logic          held, take, advance, release_w, last_word;
  logic [AW-1:0] f_addr;
  logic [DW-1:0] f_data;
  logic [1:0]    f_size;
  logic          f_long;
  logic [2:0]    f_fc;
  pend_flags_t   flags;

  assign flags = '{tr: pend_trace, b1: pend_brk1, b0: pend_brk0};

  rwf_capture #(.AW(AW), .DW(DW)) u_cap (
    .clk(clk), .rst(rst),
    .err_valid(wr_err_valid), .err_addr(wr_err_addr), .err_data(wr_err_data),
    .err_size(wr_err_size), .err_long(wr_err_long), .err_fc(wr_err_fc),
    .release_i(release_w), .held(held), .ovf(overflow),
    .f_addr(f_addr), .f_data(f_data), .f_size(f_size), .f_long(f_long), .f_fc(f_fc)
  );

  rwf_sequencer u_seq (
    .clk(clk), .rst(rst), .held(held),
    .boundary(insn_boundary), .opreq(operand_req),
    .sink_ready(stk_ready), .last_word(last_word),
    .take(take), .advance(advance), .release_o(release_w),
    .stacking(stk_valid), .exc_req(exc_req), .op_abort(op_abort)
  );

  rwf_stacker #(.AW(AW), .DW(DW)) u_stk (
    .clk(clk), .rst(rst), .take(take), .advance(advance), .active(stk_valid),
    .flags(flags), .sr(cur_sr), .pc(next_pc),
    .f_addr(f_addr), .f_data(f_data), .f_size(f_size), .f_long(f_long), .f_fc(f_fc),
    .word(stk_data), .last_word(last_word)
  );

  AST_VALID_NEEDS_FAULT: assert property (@(posedge clk) disable iff (rst)
    stk_valid |-> held); // R9

endmodule

// File: tb/sim_rwf_tracker.sv
`timescale 1ns/1ps
module sim_rwf_tracker;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst = 1'b1;
  logic          wr_err_valid = 0;
  logic [AW-1:0] wr_err_addr = '0;
  logic [DW-1:0] wr_err_data = '0;
  logic [1:0]    wr_err_size = '0;
  logic          wr_err_long = 0;
  logic [2:0]    wr_err_fc = '0;
  logic          insn_boundary = 0, operand_req = 0;
  logic          pend_trace = 0, pend_brk1 = 0, pend_brk0 = 0;
  logic [15:0]   cur_sr = '0;
  logic [AW-1:0] next_pc = '0;
  logic          stk_ready = 1;
  logic          exc_req, op_abort, stk_valid, overflow;
  logic [15:0]   stk_data;

  rwf_tracker #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .wr_err_valid(wr_err_valid), .wr_err_addr(wr_err_addr),
    .wr_err_data(wr_err_data), .wr_err_size(wr_err_size), .wr_err_long(wr_err_long),
    .wr_err_fc(wr_err_fc), .insn_boundary(insn_boundary), .operand_req(operand_req),
    .pend_trace(pend_trace), .pend_brk1(pend_brk1), .pend_brk0(pend_brk0),
    .cur_sr(cur_sr), .next_pc(next_pc), .stk_ready(stk_ready),
    .exc_req(exc_req), .op_abort(op_abort), .stk_valid(stk_valid),
    .stk_data(stk_data), .overflow(overflow)
  );

  int checks = 0, failures = 0;
  int ready_mode = 0;
  bit done_flag = 0;

  // behavioural reference
  bit            m_held, m_stack, m_exc, m_abort, m_ovf;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_data;
  logic [1:0]    m_size;
  logic          m_long;
  logic [2:0]    m_fc;
  logic [15:0]   m_q[$];

  always @(posedge clk) begin
    if (rst) begin
      m_held = 0; m_stack = 0; m_exc = 0; m_abort = 0; m_ovf = 0; m_q.delete();
    end else begin
      bit pre_held, pre_stack;
      pre_held = m_held; pre_stack = m_stack;
      m_exc = 0; m_abort = 0;
      if (wr_err_valid) begin
        if (pre_held) m_ovf = 1;
        else begin
          m_held = 1; m_addr = wr_err_addr; m_data = wr_err_data;
          m_size = wr_err_size; m_long = wr_err_long; m_fc = wr_err_fc;
        end
      end
      if (pre_held && !pre_stack && (insn_boundary || operand_req)) begin
        m_q.delete();
        m_q.push_back({3'b000, pend_trace, pend_brk1, pend_brk0, 1'b1, 3'b000,
                       m_long, m_size, m_fc});
        m_q.push_back(cur_sr);
        m_q.push_back(next_pc[31:16]); m_q.push_back(next_pc[15:0]);
        m_q.push_back(m_addr[31:16]);  m_q.push_back(m_addr[15:0]);
        m_q.push_back(m_data[31:16]);  m_q.push_back(m_data[15:0]);
        m_stack = 1; m_exc = 1; m_abort = operand_req;
      end
      if (pre_stack && stk_ready) begin
        void'(m_q.pop_front());
        if (m_q.size() == 0) begin m_stack = 0; m_held = 0; end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  bit prev_valid = 0;
  always @(negedge clk) begin
    if (!rst && !done_flag) begin
      chk("R1 R2 R4 exc_req", 32'(exc_req), 32'(m_exc));
      chk("R3 op_abort", 32'(op_abort), 32'(m_abort));
      chk("R8 R9 stk_valid", 32'(stk_valid), 32'(m_stack));
      chk("R10 overflow", 32'(overflow), 32'(m_ovf));
      if (m_stack && stk_valid) chk("R6 R7 R8 stk_data", 32'(stk_data), 32'(m_q[0]));
      if (stk_valid && !prev_valid)
        chk("R5 ssw fixed bits", {29'd0, stk_data[15:13] == 3'b000, stk_data[9],
            stk_data[8:6] == 3'b000}, 32'd7);
      prev_valid = stk_valid;
    end
    if (ready_mode == 1) stk_ready = ($urandom_range(9) < 7);
    else stk_ready = 1'b1;
  end

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_err(input logic [31:0] a, input logic [31:0] d,
                          input logic [1:0] s, input logic l, input logic [2:0] f);
    wr_err_valid = 1; wr_err_addr = a; wr_err_data = d;
    wr_err_size = s; wr_err_long = l; wr_err_fc = f;
    cyc();
    wr_err_valid = 0;
  endtask

  task automatic strobe(input bit bnd, input bit opr);
    insn_boundary = bnd; operand_req = opr;
    cyc();
    insn_boundary = 0; operand_req = 0;
  endtask

  task automatic drain();
    int guard = 0;
    while ((m_held || stk_valid) && guard < 200) begin cyc(); guard++; end
    cyc(2);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      failures++;
      $display("FAIL R8 watchdog act=running exp=finished");
      done_flag = 1;
      summary();
      $finish;
    end
  end

  initial begin
    cyc(3);
    // R11: reset state
    chk("R11 exc_req", 32'(exc_req), 0);
    chk("R11 op_abort", 32'(op_abort), 0);
    chk("R11 stk_valid", 32'(stk_valid), 0);
    chk("R11 stk_data", 32'(stk_data), 0);
    chk("R11 overflow", 32'(overflow), 0);
    rst = 0;
    cyc(2);

    // R4: trigger with nothing held
    strobe(1, 1);
    cyc(2);

    // R1 R2: capture, wait, take at boundary, sink always ready
    cur_sr = 16'h2700; next_pc = 32'h0000_1234;
    send_err(32'hCAFE_0010, 32'h1122_3344, 2'b10, 1'b1, 3'b101);
    cyc(4);
    pend_trace = 1; next_pc = 32'h0000_1238;
    strobe(1, 0);
    pend_trace = 0; cur_sr = 16'h0000; next_pc = 32'hFFFF_FFFF;
    drain();

    // R3 R6: operand request takes early, stalling sink
    ready_mode = 1;
    send_err(32'h8000_0002, 32'hDEAD_BEEF, 2'b01, 1'b0, 3'b001);
    pend_brk1 = 1; pend_brk0 = 1; cur_sr = 16'hA51F; next_pc = 32'h4000_0000;
    strobe(0, 1);
    pend_brk1 = 0; pend_brk0 = 0;
    drain();

    // R4: trigger in the same cycle as capture is ignored
    ready_mode = 0;
    wr_err_valid = 1; wr_err_addr = 32'h0000_0F00; wr_err_data = 32'h5555_AAAA;
    insn_boundary = 1;
    cyc();
    wr_err_valid = 0; insn_boundary = 0;
    cyc(3);
    strobe(1, 0);
    drain();

    // R10: second error while pending, third while stacking; R9 reacceptance
    send_err(32'h1000_0000, 32'h0101_0101, 2'b11, 1'b0, 3'b010);
    send_err(32'h2000_0000, 32'h0202_0202, 2'b00, 1'b1, 3'b110);
    strobe(1, 0);
    send_err(32'h3000_0000, 32'h0303_0303, 2'b01, 1'b1, 3'b111);
    drain();
    send_err(32'h4000_0000, 32'h0404_0404, 2'b10, 1'b0, 3'b011);
    strobe(0, 1);
    drain();

    // random mix
    ready_mode = 1;
    for (int i = 0; i < 4000; i++) begin
      wr_err_valid  = ($urandom_range(7) == 0);
      wr_err_addr   = $urandom; wr_err_data = $urandom;
      wr_err_size   = 2'($urandom_range(3)); wr_err_long = 1'($urandom_range(1));
      wr_err_fc     = 3'($urandom_range(7));
      insn_boundary = ($urandom_range(5) == 0);
      operand_req   = ($urandom_range(9) == 0);
      pend_trace    = 1'($urandom_range(1));
      pend_brk1     = 1'($urandom_range(1));
      pend_brk0     = 1'($urandom_range(1));
      cur_sr        = 16'($urandom); next_pc = $urandom;
      cyc();
    end
    wr_err_valid = 0; insn_boundary = 0; operand_req = 0;
    drain();

    done_flag = 1;
    summary();
    $finish;
  end

endmodule